// File: doc/BRIEF.md
# B1 Frame Parity Checker and Inserter

This block runs a BIP-8 (byte-interleaved even parity) over every byte of a frame, in both directions of a frame-aligned byte stream. On the receive side it keeps the parity of the last complete frame and compares it with the B1 byte of the current frame. B1 is the byte in the second row, first column. A mismatch sets a sticky error flag. If the channel is provisioned, the flag also drives an active-low interrupt. A status read strobe clears the flag.

On the transmit side it replaces the outgoing B1 byte with the parity of the previous frame exactly as it left the block, so any earlier insertion is included. Frame position comes from row and column counters supplied alongside each byte, so no framer or scrambler lives here.

Checking and insertion are switched on by either a hardware pin or a soft control bit. Only when both are low does the block stop comparing and pass the transmit B1 byte through untouched. The parity accumulators keep running in every case.

Top module: `b1_parity`

## Requirements
- R1: A frame starts on a valid byte at row 0, column 0. The parity of a frame is the XOR of all its valid bytes, including its own B1 byte. It is taken as complete at the start of the next frame.
- R2: A valid receive byte at row 1, column 0 that differs from the previous frame's parity sets the error flag `perr` on the next clock. This applies when parity is enabled, the stream is aligned and a previous parity exists.
- R3: `perr` stays set until `stat_rd` is high in a cycle with no new mismatch. It reads 0 on the clock after that read. It is 0 after reset.
- R4: When a mismatch and `stat_rd` occur in the same cycle, `perr` is 1 on the next clock.
- R5: `irq_n` is low exactly when `perr` is 1 and `chan_prov` is 1. Otherwise it is high.
- R6: No receive comparison is made until one complete frame has been seen since `rx_aligned` rose. Driving `rx_aligned` low discards all receive parity state.
- R7: On transmit, each valid byte appears on `tx_byte_out` one clock later with `tx_vld_out` high. At row 1, column 0 the byte is replaced by the parity of the previous outgoing frame, taken on the bytes as sent.
- R8: Parity is enabled when `par_pin` or `par_soft` is 1. When both are 0, no mismatch sets `perr` and the transmit B1 byte passes through unchanged.
- R9: The transmit B1 byte passes through unchanged until one complete outgoing frame has been seen after reset.
- R10: Cycles with the valid input low add nothing to either parity and yield `tx_vld_out` 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_pin | input | 1 | Hardware parity enable |
| par_soft | input | 1 | Soft parity enable bit |
| chan_prov | input | 1 | Channel provisioned, gates the interrupt |
| stat_rd | input | 1 | Status register read strobe, clears `perr` |
| rx_aligned | input | 1 | Receive stream is in frame |
| rx_vld | input | 1 | Receive byte valid |
| rx_row | input | RW | Receive row counter |
| rx_col | input | CW | Receive column counter |
| rx_byte | input | 8 | Receive byte, as scrambled |
| tx_vld | input | 1 | Transmit byte valid |
| tx_row | input | RW | Transmit row counter |
| tx_col | input | CW | Transmit column counter |
| tx_byte_in | input | 8 | Transmit byte after switching and scrambling |
| tx_byte_out | output | 8 | Transmit byte with B1 inserted |
| tx_vld_out | output | 1 | Transmit output valid |
| perr | output | 1 | Sticky receive parity error |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with a 3-row by 6-column frame, which is 18 bytes per frame instead of the full-rate 9 by 1080. This short frame brings many frame boundaries, repeated B1 positions and realignment events within a few hundred cycles. The B1 position is still the second row, first column. That keeps the first-row bytes before it and the later rows after it, so the parity still spans bytes on both sides of B1.

// File: rtl/b1_pkg.sv
package b1_pkg;
    typedef logic [7:0] byte_t;

    // B1 sits in the second row, first column of a frame.
    localparam int B1_ROW = 1;
    localparam int B1_COL = 0;

    typedef struct packed {
        byte_t acc;
        byte_t prev;
        logic  started;
        logic  prev_ok;
    } bip_st_t;

    typedef struct packed {
        logic flag;
    } chk_st_t;

    typedef struct packed {
        byte_t data;
        logic  vld;
    } tx_st_t;
endpackage

// File: rtl/b1_pos_dec.sv
module b1_pos_dec #(
    parameter int ROWS = 9,
    parameter int COLS = 1080,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          vld,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic          sof,
    output logic          at_b1
);
    import b1_pkg::*;
    localparam logic [RW-1:0] B1R = RW'(B1_ROW);
    localparam logic [CW-1:0] B1C = CW'(B1_COL);

    always_comb begin
        sof   = vld && (row == '0) && (col == '0);
        at_b1 = vld && (row == B1R) && (col == B1C);
    end
endmodule

// File: rtl/b1_bip_acc.sv
module b1_bip_acc (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         vld,
    input  logic         sof,
    input  b1_pkg::byte_t data,
    output b1_pkg::byte_t prev,
    output logic         prev_ok
);
    import b1_pkg::*;
    bip_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc     = '0;
            st_d.started = 1'b0;
            st_d.prev_ok = 1'b0;
        end else if (vld) begin
            if (sof) begin
                st_d.acc     = data;
                st_d.started = 1'b1;
                if (st_q.started) begin
                    st_d.prev    = st_q.acc;
                    st_d.prev_ok = 1'b1;
                end
            end else begin
                st_d.acc = st_q.acc ^ data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev    = st_q.prev;
    assign prev_ok = st_q.prev_ok;

    p_clr_drops_prev_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !prev_ok);
    p_second_sof_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && vld && sof && st_q.started) |=> prev_ok);
    p_idle_holds_prev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vld) |=> $stable(prev) && $stable(prev_ok));
endmodule

// File: rtl/b1_rx_check.sv
module b1_rx_check (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hit_b1,
    input  b1_pkg::byte_t data,
    input  b1_pkg::byte_t prev,
    input  logic          prev_ok,
    input  logic          rd,
    output logic          flag
);
    import b1_pkg::*;
    chk_st_t st_d, st_q;
    logic    mis;

    always_comb begin
        mis  = hit_b1 && en && prev_ok && (data != prev);
        st_d = st_q;
        if (mis)     st_d.flag = 1'b1;
        else if (rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    p_mismatch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mis |=> flag);
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mis) |=> !flag);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd) |=> flag);
    p_error_beats_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mis && rd) |=> flag);
    p_off_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag) |=> !flag);
endmodule

// File: rtl/b1_tx_insert.sv
module b1_tx_insert (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vld,
    input  logic          hit_b1,
    input  b1_pkg::byte_t data_in,
    input  b1_pkg::byte_t prev,
    input  logic          prev_ok,
    output b1_pkg::byte_t data_d,
    output b1_pkg::byte_t data_q,
    output logic          vld_q
);
    import b1_pkg::*;
    tx_st_t st_d, st_q;
    logic   ins;

    always_comb begin
        ins       = hit_b1 && en && prev_ok;
        st_d.data = ins ? prev : data_in;
        st_d.vld  = vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_d = st_d.data;
    assign data_q = st_q.data;
    assign vld_q  = st_q.vld;

    p_plain_bytes_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !hit_b1) |=> (data_q == $past(data_in)) && vld_q);
    p_disabled_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !en) |=> data_q == $past(data_in));
    p_no_prev_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !prev_ok) |=> data_q == $past(data_in));
    p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> !vld_q);
endmodule

// File: rtl/b1_parity.sv
module b1_parity #(
    parameter int ROWS = 9,
    parameter int COLS = 1080,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_pin,
    input  logic          par_soft,
    input  logic          chan_prov,
    input  logic          stat_rd,
    input  logic          rx_aligned,
    input  logic          rx_vld,
    input  logic [RW-1:0] rx_row,
    input  logic [CW-1:0] rx_col,
    input  logic [7:0]    rx_byte,
    input  logic          tx_vld,
    input  logic [RW-1:0] tx_row,
    input  logic [CW-1:0] tx_col,
    input  logic [7:0]    tx_byte_in,
    output logic [7:0]    tx_byte_out,
    output logic          tx_vld_out,
    output logic          perr,
    output logic          irq_n
);
    import b1_pkg::*;

    logic  par_en;
    logic  rx_in_vld, rx_sof, rx_b1;
    logic  tx_sof, tx_b1;
    byte_t rx_prev, tx_prev, tx_next;
    logic  rx_prev_ok, tx_prev_ok;

    always_comb begin
        par_en    = par_pin | par_soft;
        rx_in_vld = rx_vld && rx_aligned;
        irq_n     = !(perr && chan_prov);
    end

    b1_pos_dec #(.ROWS(ROWS), .COLS(COLS)) u_rx_pos (
        .vld(rx_in_vld), .row(rx_row), .col(rx_col), .sof(rx_sof), .at_b1(rx_b1));

    b1_pos_dec #(.ROWS(ROWS), .COLS(COLS)) u_tx_pos (
        .vld(tx_vld), .row(tx_row), .col(tx_col), .sof(tx_sof), .at_b1(tx_b1));

    b1_bip_acc u_rx_acc (
        .clk(clk), .rst_n(rst_n), .clr(!rx_aligned), .vld(rx_in_vld), .sof(rx_sof),
        .data(rx_byte), .prev(rx_prev), .prev_ok(rx_prev_ok));

    b1_rx_check u_rx_chk (
        .clk(clk), .rst_n(rst_n), .en(par_en), .hit_b1(rx_b1), .data(rx_byte),
        .prev(rx_prev), .prev_ok(rx_prev_ok), .rd(stat_rd), .flag(perr));

    // Transmit parity runs on the bytes as they leave, inserted B1 included.
    b1_tx_insert u_tx_ins (
        .clk(clk), .rst_n(rst_n), .en(par_en), .vld(tx_vld), .hit_b1(tx_b1),
        .data_in(tx_byte_in), .prev(tx_prev), .prev_ok(tx_prev_ok),
        .data_d(tx_next), .data_q(tx_byte_out), .vld_q(tx_vld_out));

    b1_bip_acc u_tx_acc (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .vld(tx_vld), .sof(tx_sof),
        .data(tx_next), .prev(tx_prev), .prev_ok(tx_prev_ok));

    p_unprov_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_prov |-> irq_n);
    p_unaligned_no_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_aligned && !perr) |=> !perr);
endmodule

// File: tb/sim_b1_parity.sv
module sim_b1_parity;
    localparam int ROWS = 3;
    localparam int COLS = 6;
    localparam int RW = 2;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_pin = 1'b0, par_soft = 1'b0, chan_prov = 1'b0, stat_rd = 1'b0;
    logic rx_aligned = 1'b0, rx_vld = 1'b0, tx_vld = 1'b0;
    logic [RW-1:0] rx_row = '0, tx_row = '0;
    logic [CW-1:0] rx_col = '0, tx_col = '0;
    logic [7:0] rx_byte = '0, tx_byte_in = '0;
    logic [7:0] tx_byte_out;
    logic tx_vld_out, perr, irq_n;

    always #5 clk = ~clk;

    b1_parity #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk(clk), .rst_n(rst_n), .par_pin(par_pin), .par_soft(par_soft),
        .chan_prov(chan_prov), .stat_rd(stat_rd), .rx_aligned(rx_aligned),
        .rx_vld(rx_vld), .rx_row(rx_row), .rx_col(rx_col), .rx_byte(rx_byte),
        .tx_vld(tx_vld), .tx_row(tx_row), .tx_col(tx_col), .tx_byte_in(tx_byte_in),
        .tx_byte_out(tx_byte_out), .tx_vld_out(tx_vld_out), .perr(perr), .irq_n(irq_n));

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: frames kept as byte queues and folded on demand.
    logic [7:0] q_rx[$];
    logic [7:0] q_tx[$];
    logic [7:0] m_rx_prev = 0, m_tx_prev = 0, m_txo = 0;
    bit m_rx_started = 0, m_rx_ok = 0, m_tx_started = 0, m_tx_ok = 0;
    bit m_txv = 0, m_perr = 0;

    function automatic logic [7:0] fold(input logic [7:0] q[$]);
        logic [7:0] x = 0;
        foreach (q[i]) x = x ^ q[i];
        return x;
    endfunction

    task automatic model_edge();
        bit en, mis, b1r, b1t, sofr, soft_;
        logic [7:0] o;
        if (!rst_n) begin
            q_rx.delete(); q_tx.delete();
            m_rx_started = 0; m_rx_ok = 0; m_tx_started = 0; m_tx_ok = 0;
            m_txv = 0; m_txo = 0; m_perr = 0;
            return;
        end
        en   = par_pin || par_soft;
        b1r  = (rx_row == 1) && (rx_col == 0);
        sofr = (rx_row == 0) && (rx_col == 0);
        b1t  = (tx_row == 1) && (tx_col == 0);
        soft_ = (tx_row == 0) && (tx_col == 0);
        mis = rx_aligned && rx_vld && b1r && en && m_rx_ok && (rx_byte != m_rx_prev);
        if (mis) m_perr = 1;
        else if (stat_rd) m_perr = 0;
        if (!rx_aligned) begin
            q_rx.delete(); m_rx_started = 0; m_rx_ok = 0;
        end else if (rx_vld) begin
            if (sofr) begin
                if (m_rx_started) begin m_rx_prev = fold(q_rx); m_rx_ok = 1; end
                q_rx.delete(); m_rx_started = 1;
            end
            if (m_rx_started) q_rx.push_back(rx_byte);
        end
        o = (tx_vld && b1t && en && m_tx_ok) ? m_tx_prev : tx_byte_in;
        m_txo = o;
        m_txv = tx_vld;
        if (tx_vld) begin
            if (soft_) begin
                if (m_tx_started) begin m_tx_prev = fold(q_tx); m_tx_ok = 1; end
                q_tx.delete(); m_tx_started = 1;
            end
            if (m_tx_started) q_tx.push_back(o);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tx_vld_out === m_txv, "R10 tx_vld_out", tx_vld_out, m_txv);
        if (m_txv) chk(tx_byte_out === m_txo, "R7 R9 tx_byte_out", tx_byte_out, m_txo);
        chk(perr === m_perr, "R3 perr model", perr, m_perr);
        chk(irq_n === !(m_perr && chan_prov), "R5 irq_n model", irq_n, !(m_perr && chan_prov));
    endtask

    logic [7:0] seed = 8'h3c;
    logic [7:0] gen_acc = 0, gen_prev = 0;

    task automatic idle(input int n);
        rx_vld = 0; tx_vld = 0; stat_rd = 0;
        repeat (n) tick();
    endtask

    task automatic send_frame(input logic [7:0] flip, input bit rd_b1, input int gap);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic [7:0] b;
                if (gap > 0 && ((r * COLS + c) % gap) == gap - 1) idle(1);
                seed = seed * 8'd5 + 8'd17;
                tx_byte_in = seed ^ 8'h96;
                if (r == 0 && c == 0) begin gen_prev = gen_acc; gen_acc = 0; end
                b = (r == 1 && c == 0) ? (gen_prev ^ flip) : seed;
                gen_acc = gen_acc ^ b;
                rx_byte = b;
                rx_row = RW'(r); rx_col = CW'(c);
                tx_row = RW'(r); tx_col = CW'(c);
                rx_vld = 1; tx_vld = 1;
                stat_rd = rd_b1 && (r == 1) && (c == 0);
                tick();
            end
        end
        idle(1);
    endtask

    task automatic read_status();
        stat_rd = 1; rx_vld = 0; tx_vld = 0;
        tick();
        stat_rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        chk(perr === 1'b0, "R3 reset perr", perr, 0);
        chk(irq_n === 1'b1, "R5 reset irq_n", irq_n, 1);
        chk(tx_vld_out === 1'b0, "R10 reset tx_vld_out", tx_vld_out, 0);
        rst_n = 1; par_pin = 1; chan_prov = 1; rx_aligned = 1;
        idle(1);

        send_frame(8'h5a, 0, 0);
        chk(perr === 1'b0, "R6 first frame not compared", perr, 0);
        send_frame(8'h00, 0, 0);
        chk(perr === 1'b0, "R1 correct B1 accepted", perr, 0);
        send_frame(8'h01, 0, 0);
        chk(perr === 1'b1, "R2 corrupt B1 flagged", perr, 1);
        chk(irq_n === 1'b0, "R5 irq low when provisioned", irq_n, 0);
        chan_prov = 0; idle(1);
        chk(irq_n === 1'b1, "R5 irq high when unprovisioned", irq_n, 1);
        chan_prov = 1;
        send_frame(8'h00, 0, 0);
        chk(perr === 1'b1, "R3 flag sticky", perr, 1);
        read_status();
        chk(perr === 1'b0, "R3 read clears", perr, 0);

        send_frame(8'h80, 1, 0);
        chk(perr === 1'b1, "R4 error wins over read", perr, 1);
        read_status();

        par_pin = 0; par_soft = 0;
        send_frame(8'hff, 0, 0);
        chk(perr === 1'b0, "R8 disabled no compare", perr, 0);
        par_soft = 1;
        send_frame(8'h00, 0, 0);
        chk(perr === 1'b0, "R8 soft enable correct", perr, 0);
        send_frame(8'h10, 0, 0);
        chk(perr === 1'b1, "R8 soft enable flags", perr, 1);
        read_status();

        send_frame(8'h00, 0, 4);
        chk(perr === 1'b0, "R10 gaps ignored", perr, 0);
        send_frame(8'h03, 0, 3);
        chk(perr === 1'b1, "R10 gaps corrupt flagged", perr, 1);
        read_status();

        rx_aligned = 0; idle(2); rx_aligned = 1;
        send_frame(8'h77, 0, 0);
        chk(perr === 1'b0, "R6 realign first frame skipped", perr, 0);
        send_frame(8'h00, 0, 0);
        chk(perr === 1'b0, "R6 realign correct", perr, 0);
        send_frame(8'h02, 0, 0);
        chk(perr === 1'b1, "R6 realign then error", perr, 1);
        read_status();
        idle(2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule